// File: doc/BRIEF.md
# PCI configuration access master

This block turns one processor-side access to a configuration data location into a single PCI configuration read or write. The requester presents a configuration address (bus, device, function and register number), a write value, an access size and a direction, and pulses `req_valid`. The block chooses the configuration cycle type from the bus number. For a Type 0 cycle it picks the IDSEL line from the device number. It steps the address for one clock, then runs one data phase on a simplified master port. If no target claims the cycle, the block ends it with a master abort.

A Type 0 access to device 0 never reaches the bus. A small local register file serves it. Two completion modes exist. In blocking mode the requester is acknowledged only when the access ends. In decoupled mode it is acknowledged at once and follows progress through busy, done and error status bits. The caller fixes the mode, and the error-enable setting, per request.

Field layout of `cfg_addr`: bus number [23:16], device [15:11], function [10:8], register [7:2]. Bits [1:0] are ignored.

Top module: `pci_cfg_master`

## Requirements
- R1: A bus number of zero gives a Type 0 cycle. Any other bus number gives a Type 1 cycle. The Type 1 address phase drives AD[31]=0, AD[30:2]=cfg_addr[30:2] and AD[1:0]=01.
- R2: A Type 0 address phase drives AD[1:0]=00 and AD[10:2]=cfg_addr[10:2]. For device n in 1..21 it sets only AD[10+n] among AD[31:11]. For device 22..31 it leaves AD[31:11] at zero.
- R3: A Type 0 access to device 0 never asserts FRAME# and uses the local register file (16 words, indexed by cfg_addr[5:2]). A write updates only the enabled bytes. A read returns the stored word on `rdata`.
- R4: During the address phase C/BE# carries 1010 for a read and 1011 for a write. During the data phase C/BE# (active low) enables lane 0 only for size 0, lanes 0-1 for size 1, lanes 0-2 for size 2 and all lanes for size 3.
- R5: The address and command are driven for exactly one clock with FRAME# high before FRAME# is asserted for one clock. The single data phase follows, with FRAME# high and IRDY# low.
- R6: The data phase ends on the first clock where DEVSEL# and TRDY# are both low. On a read, AD is captured into `rdata`. A DEVSEL# seen earlier without TRDY# keeps the phase open with no time limit.
- R7: If DEVSEL# has not been seen by the 5th clock after the FRAME# clock, the access ends as a master abort. `st_error` is set, and a read returns 0xFFFF_FFFF on `rdata`.
- R8: A master abort sets the sticky bit `st_rma`. A `rma_clr` pulse clears it. If an abort completes in the same clock as a clear, the bit stays set.
- R9: In blocking mode `req_ack` pulses for one clock after the access ends. On an abort with error enable set, `req_err` pulses with it.
- R10: In decoupled mode `req_ack` pulses in the clock after acceptance, and `req_err` never pulses. `st_busy` is high while the access runs. `st_done` and `st_error` clear on acceptance, and `st_done` sets when the access ends.
- R11: A request arriving while busy is refused. `req_retry` pulses for one clock, and the running access and status are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | one-clock request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 31 | configuration address fields |
| req_size | input | 2 | 0 byte, 1 half, 2 three bytes, 3 word |
| wdata | input | 32 | write value |
| decoupled | input | 1 | decoupled completion mode for this request |
| err_en | input | 1 | error acknowledge enable for this request |
| rma_clr | input | 1 | clear the sticky master-abort bit |
| req_ack | output | 1 | request acknowledge pulse |
| req_err | output | 1 | error acknowledge pulse |
| req_retry | output | 1 | refused-request pulse |
| rdata | output | 32 | read result |
| st_busy | output | 1 | access in progress |
| st_done | output | 1 | last access finished |
| st_error | output | 1 | last access master-aborted |
| st_rma | output | 1 | sticky received master abort |
| ad_out | output | 32 | AD bus value driven |
| ad_oe | output | 1 | AD output enable |
| cbe_n | output | 4 | command / byte enables |
| frame_n | output | 1 | FRAME# |
| irdy_n | output | 1 | IRDY# |
| devsel_n | input | 1 | DEVSEL# from target |
| trdy_n | input | 1 | TRDY# from target |
| ad_in | input | 32 | AD bus value from target |

## Verification
Two events can fall on the same edge: a master abort that sets the sticky abort bit, and a requester clear pulse for that bit. The bench holds `rma_clr` high through a whole unanswered access, so the clear and the abort meet on the abort clock. It expects the bit to read set afterwards. A second collision is a new request arriving on the same clock an access completes. The bench pulses a request at that point and expects a retry pulse and unchanged status. A behavioural reference model compares every output on every clock.

// File: rtl/pci_cfg_master.sv
`timescale 1ns/1ps
module pci_cfg_master #(
  parameter int ABORT_CLKS  = 5,
  parameter int LOCAL_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [30:0] cfg_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] wdata,
  input  logic        decoupled,
  input  logic        err_en,
  input  logic        rma_clr,
  output logic        req_ack,
  output logic        req_err,
  output logic        req_retry,
  output logic [31:0] rdata,
  output logic        st_busy,
  output logic        st_done,
  output logic        st_error,
  output logic        st_rma,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic [3:0]  cbe_n,
  output logic        frame_n,
  output logic        irdy_n,
  input  logic        devsel_n,
  input  logic        trdy_n,
  input  logic [31:0] ad_in
);
  localparam int LIDX = $clog2(LOCAL_WORDS);
  localparam int CW   = $clog2(ABORT_CLKS + 1);
  localparam logic [4:0] MAX_IDSEL = 5'd21;

  typedef enum logic [2:0] {S_IDLE, S_LOCAL, S_STEP, S_ADDR, S_DATA} st_t;
  st_t st;

  logic [30:0] addr_q;
  logic [31:0] wdata_q;
  logic [1:0]  size_q;
  logic        wr_q, dec_q, een_q, seen_q;
  logic [CW-1:0] cnt;
  logic [31:0] lmem [LOCAL_WORDS];

  wire [7:0] bus_f = addr_q[23:16];
  wire [4:0] dev_f = addr_q[15:11];
  wire [LIDX-1:0] lidx = addr_q[LIDX+1:2];

  wire [31:0] idsel = (dev_f != 5'd0 && dev_f <= MAX_IDSEL) ?
                      (32'd1 << ({1'b0, dev_f} + 6'd10)) : 32'd0;
  wire [31:0] paddr = (bus_f != 8'd0) ? {1'b0, addr_q[30:2], 2'b01}
                                      : (idsel | {21'd0, addr_q[10:2], 2'b00});
  wire [3:0] cmd = wr_q ? 4'b1011 : 4'b1010;

  logic [3:0] be_n;
  always_comb begin
    case (size_q)
      2'd0:    be_n = 4'b1110;
      2'd1:    be_n = 4'b1100;
      2'd2:    be_n = 4'b1000;
      default: be_n = 4'b0000;
    endcase
  end

  wire in_addr = (st == S_STEP) || (st == S_ADDR);
  assign ad_oe   = in_addr || (st == S_DATA && wr_q);
  assign ad_out  = in_addr ? paddr : ((st == S_DATA && wr_q) ? wdata_q : 32'd0);
  assign cbe_n   = in_addr ? cmd : ((st == S_DATA) ? be_n : 4'hF);
  assign frame_n = (st != S_ADDR);
  assign irdy_n  = (st != S_DATA);
  assign st_busy = (st != S_IDLE);

  wire hit   = (st == S_DATA) && !devsel_n && !trdy_n;
  wire abort = (st == S_DATA) && devsel_n && !seen_q && (cnt == CW'(ABORT_CLKS));
  wire to_local = (cfg_addr[23:11] == 13'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0; wdata_q <= '0; size_q <= '0;
      wr_q <= 1'b0; dec_q <= 1'b0; een_q <= 1'b0; seen_q <= 1'b0;
      cnt <= '0; rdata <= '0;
      req_ack <= 1'b0; req_err <= 1'b0; req_retry <= 1'b0;
      st_done <= 1'b0; st_error <= 1'b0; st_rma <= 1'b0;
      for (int i = 0; i < LOCAL_WORDS; i++) lmem[i] <= '0;
    end else begin
      req_ack <= 1'b0;
      req_err <= 1'b0;
      req_retry <= st_busy && req_valid;
      if (rma_clr) st_rma <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= cfg_addr; wdata_q <= wdata; size_q <= req_size;
          wr_q <= req_write; dec_q <= decoupled; een_q <= err_en;
          seen_q <= 1'b0; st_done <= 1'b0; st_error <= 1'b0;
          req_ack <= decoupled;
          st <= to_local ? S_LOCAL : S_STEP;
        end
        S_LOCAL: begin
          if (wr_q) begin
            for (int b = 0; b < 4; b++)
              if (!be_n[b]) lmem[lidx][8*b +: 8] <= wdata_q[8*b +: 8];
          end else begin
            rdata <= lmem[lidx];
          end
          st <= S_IDLE; st_done <= 1'b1; req_ack <= !dec_q;
        end
        S_STEP: st <= S_ADDR;
        S_ADDR: begin
          cnt <= CW'(1);
          st <= S_DATA;
        end
        S_DATA: begin
          if (hit) begin
            if (!wr_q) rdata <= ad_in;
            st <= S_IDLE; st_done <= 1'b1; req_ack <= !dec_q;
          end else if (abort) begin
            if (!wr_q) rdata <= '1;
            st <= S_IDLE; st_done <= 1'b1; req_ack <= !dec_q;
            st_error <= 1'b1; st_rma <= 1'b1;
            req_err <= !dec_q && een_q;
          end else begin
            if (!devsel_n) seen_q <= 1'b1;
            if (cnt != CW'(ABORT_CLKS)) cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_STEP_BEFORE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(ad_oe) && $stable(ad_out) && $past(irdy_n)); // R5
  AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !irdy_n |-> frame_n); // R5
  AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCAL) |-> frame_n && !ad_oe); // R3
  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_error) && !wr_q) |-> (rdata == 32'hFFFF_FFFF)); // R7
  AST_RMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_rma) |-> $past(rma_clr)); // R8
  AST_RETRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_retry |-> $past(st_busy)); // R11
  AST_DEC_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> req_ack && $rose(st_error)); // R9
endmodule

// File: tb/sim_pci_cfg_master.sv
`timescale 1ns/1ps
module sim_pci_cfg_master;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, decoupled = 0, err_en = 0, rma_clr = 0;
  logic [30:0] cfg_addr = '0;
  logic [1:0] req_size = 0;
  logic [31:0] wdata = 0, ad_in = 0;
  logic devsel_n = 1, trdy_n = 1;
  logic req_ack, req_err, req_retry, st_busy, st_done, st_error, st_rma, ad_oe, frame_n, irdy_n;
  logic [31:0] rdata, ad_out;
  logic [3:0] cbe_n;

  pci_cfg_master u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .cfg_addr(cfg_addr), .req_size(req_size), .wdata(wdata), .decoupled(decoupled),
    .err_en(err_en), .rma_clr(rma_clr), .req_ack(req_ack), .req_err(req_err),
    .req_retry(req_retry), .rdata(rdata), .st_busy(st_busy), .st_done(st_done),
    .st_error(st_error), .st_rma(st_rma), .ad_out(ad_out), .ad_oe(ad_oe), .cbe_n(cbe_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .devsel_n(devsel_n), .trdy_n(trdy_n), .ad_in(ad_in));

  int total = 0, bad = 0, cyc = 0, frame_lows = 0;
  int t_dsel = 1, t_trdy = 1;
  logic [31:0] t_data = 0;

  // reference model state
  int m_ph = 0, k;
  logic m_wr, m_dec, m_een, m_seen, m_ack, m_rerr, m_retry, m_done, m_err, m_rma, fin, ab;
  logic [30:0] m_addr;
  logic [31:0] m_wdata, m_rdata;
  logic [1:0] m_size;
  logic [31:0] m_mem [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] exp_addr();
    logic [31:0] v;
    int d;
    v = 0;
    if (m_addr[23:16] != 0) begin
      v = {1'b0, m_addr[30:2], 2'b01};
    end else begin
      d = int'(m_addr[15:11]);
      if (d >= 1 && d <= 21) v[10 + d] = 1'b1;
      v[10:2] = m_addr[10:2];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ack = 0; m_rerr = 0; m_retry = 0; m_done = 0; m_err = 0; m_rma = 0;
      m_rdata = 0; m_wr = 0; m_dec = 0; m_een = 0; m_seen = 0; m_addr = 0; m_wdata = 0; m_size = 0;
      for (int i = 0; i < 16; i++) m_mem[i] = 0;
    end else begin
      m_ack = 0; m_rerr = 0; fin = 0; ab = 0;
      m_retry = (m_ph != 0) && req_valid;
      if (rma_clr) m_rma = 0;
      if (m_ph == 0) begin
        if (req_valid) begin
          m_addr = cfg_addr; m_wdata = wdata; m_size = req_size; m_wr = req_write;
          m_dec = decoupled; m_een = err_en; m_seen = 0; m_done = 0; m_err = 0;
          m_ack = decoupled;
          m_ph = (cfg_addr[23:16] == 0 && cfg_addr[15:11] == 0) ? -1 : 1;
        end
      end else if (m_ph == -1) begin
        if (m_wr) begin
          for (int b = 0; b < 4; b++)
            if (b <= int'(m_size)) m_mem[m_addr[5:2]][8*b +: 8] = m_wdata[8*b +: 8];
        end else m_rdata = m_mem[m_addr[5:2]];
        fin = 1;
      end else if (m_ph < 3) begin
        m_ph++;
      end else begin
        k = m_ph - 2;
        if (!devsel_n && !trdy_n) begin
          if (!m_wr) m_rdata = ad_in;
          fin = 1;
        end else if (devsel_n && !m_seen && k == 5) begin
          fin = 1; ab = 1;
        end else begin
          if (!devsel_n) m_seen = 1;
          m_ph++;
        end
      end
      if (fin) begin
        m_ph = 0; m_done = 1; m_ack = !m_dec;
        if (ab) begin
          m_err = 1; m_rma = 1;
          if (!m_wr) m_rdata = 32'hFFFF_FFFF;
          m_rerr = !m_dec && m_een;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!frame_n && m_ph == 0) frame_lows++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog R5 act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      chk("R5 frame_n", frame_n, m_ph != 2);
      chk("R5 irdy_n", irdy_n, !(m_ph >= 3));
      chk("R1/R2 ad_oe", ad_oe, (m_ph == 1 || m_ph == 2 || (m_ph >= 3 && m_wr)));
      if (m_ph == 1 || m_ph == 2) chk("R1/R2 address", ad_out, exp_addr());
      if (m_ph >= 3 && m_wr) chk("R6 write data", ad_out, m_wdata);
      if (m_ph == 1 || m_ph == 2) chk("R4 command", cbe_n, m_wr ? 4'b1011 : 4'b1010);
      else if (m_ph >= 3) chk("R4 byte enables", cbe_n, 4'((4'hF << (int'(m_size) + 1))));
      else chk("R4 idle cbe", cbe_n, 4'hF);
      chk("R6/R3 rdata", rdata, m_rdata);
      chk("R10 busy", st_busy, m_ph != 0);
      chk("R10 done", st_done, m_done);
      chk("R7 error", st_error, m_err);
      chk("R8 rma", st_rma, m_rma);
      chk("R9 ack", req_ack, m_ack);
      chk("R9 req_err", req_err, m_rerr);
      chk("R11 retry", req_retry, m_retry);
    end
    #1;
    k = (m_ph >= 3) ? m_ph - 2 : 0;
    devsel_n = !(k >= 1 && k >= t_dsel);
    trdy_n = !(k >= 1 && k >= t_trdy);
    ad_in = t_data;
  end

  task automatic pulse(input logic wr, input logic [30:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input logic dec, input logic een);
    @(negedge clk); #1;
    req_valid = 1; req_write = wr; cfg_addr = a; req_size = sz; wdata = d;
    decoupled = dec; err_en = een;
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (m_ph != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [30:0] ca(input int bus, input int dev, input int fn, input int rg);
    return {7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b00};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset busy", st_busy, 0);
    chk("R5 reset frame", frame_n, 1);
    #1 rst_n = 1;
    // R3 local accesses
    pulse(1, ca(0, 0, 0, 3), 2'd3, 32'hA1B2C3D4, 0, 0); wait_idle();
    pulse(1, ca(0, 0, 0, 3), 2'd0, 32'h000000EE, 0, 0); wait_idle();
    pulse(0, ca(0, 0, 0, 3), 2'd3, 0, 0, 0); wait_idle();
    chk("R3 local rdata", rdata, 32'hA1B2C3EE);
    chk("R3 no FRAME#", frame_lows, 0);
    // R2 Type 0 reads/writes
    t_dsel = 1; t_trdy = 1; t_data = 32'h12345678;
    pulse(0, ca(0, 1, 2, 16), 2'd3, 0, 0, 0); wait_idle();
    chk("R6 read capture", rdata, 32'h12345678);
    t_dsel = 2; t_trdy = 3;
    pulse(1, ca(0, 21, 7, 63), 2'd2, 32'hCAFEF00D, 0, 0); wait_idle();
    // R1 Type 1
    t_data = 32'h0BADBEEF;
    pulse(0, ca(5, 0, 1, 4), 2'd1, 0, 0, 0); wait_idle();
    chk("R1 type1 read", rdata, 32'h0BADBEEF);
    // R6 late TRDY beyond abort window
    t_dsel = 2; t_trdy = 8; t_data = 32'h55AA55AA;
    pulse(0, ca(9, 3, 0, 2), 2'd3, 0, 0, 0); wait_idle();
    chk("R6 no abort after DEVSEL#", st_error, 0);
    // R7 abort, blocking, error enable
    t_dsel = 99; t_trdy = 99;
    pulse(0, ca(0, 22, 0, 1), 2'd3, 0, 0, 1); wait_idle();
    chk("R7 abort read ones", rdata, 32'hFFFFFFFF);
    chk("R8 rma set", st_rma, 1);
    @(negedge clk); #1 rma_clr = 1; @(negedge clk); #1 rma_clr = 0;
    @(negedge clk);
    chk("R8 rma cleared", st_rma, 0);
    pulse(1, ca(2, 4, 0, 1), 2'd0, 32'h11, 0, 0); wait_idle();
    // R8 collision: clear held during abort completion
    #1 rma_clr = 1;
    pulse(0, ca(0, 30, 0, 1), 2'd3, 0, 0, 1);
    while (m_ph != 0) @(negedge clk);
    #1 rma_clr = 0;
    @(negedge clk);
    chk("R8 set wins over clear", st_rma, 1);
    // R10/R11 decoupled with a refused request
    t_dsel = 1; t_trdy = 2; t_data = 32'h7777AAAA;
    pulse(0, ca(1, 2, 3, 5), 2'd3, 0, 1, 1);
    pulse(1, ca(0, 0, 0, 4), 2'd3, 32'hDEAD0000, 0, 0);
    wait_idle();
    chk("R10 decoupled data", rdata, 32'h7777AAAA);
    // R11 request on completion clock
    t_dsel = 1; t_trdy = 1;
    pulse(0, ca(0, 5, 0, 2), 2'd3, 0, 0, 0);
    @(negedge clk); @(negedge clk); #1 req_valid = 1; req_write = 1; cfg_addr = ca(0, 0, 0, 4);
    @(negedge clk); #1 req_valid = 0;
    wait_idle();
    // R10 decoupled abort
    t_dsel = 99; t_trdy = 99;
    pulse(1, ca(3, 1, 0, 0), 2'd1, 32'h1, 1, 1); wait_idle();
    chk("R10 decoupled error", st_error, 1);
    pulse(0, ca(0, 0, 0, 4), 2'd3, 0, 0, 0); wait_idle();
    chk("R11 refused write left no trace", rdata, 0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule